// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block watches sixteen external request inputs and turns each one into a level request for a downstream priority unit. Each channel's input comes from its own pin. On channels 2 to 15, a register bit can instead select a second, alternative input. The selected input passes through a two-stage synchronizer. A per-channel detector then looks for a low level, a falling edge, a rising edge or either edge. A detected condition sets a sticky per-channel flag. The flag ANDed with a per-channel enable bit is the channel's request output.

Software configures the block through a small word-wide register port: two sense-mode words, a source-select word, an enable word and a flag word. A flag is cleared by writing 0 to its bit. The clear takes effect only for flags that a read of the flag word returned as 1 since the last write to that word. This guards against losing a request that arrives between the read and the clear. The block has no streaming data path. All of its pins are plain control and status signals, so no valid/ready handshake and no back-pressure apply.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is 0. The registers are decoded at word addresses: 0 holds the sense modes of channels 0 to 7 and 1 holds those of channels 8 to 15 (channel k at bits 2k+1:2k within its word). Address 2 is source select, 3 is enable and 4 is flags. Addresses 5 to 7 read 0.
- R2: The selected input is synchronized by two flip-flops. An edge is a difference between the newest synchronized sample and the one before it. A flag therefore becomes visible on the third rising clock edge after the input changes.
- R3: Sense mode 2'b00 detects a low level, 2'b01 a falling edge, 2'b10 a rising edge and 2'b11 either edge. No other condition sets the flag.
- R4: In low-level mode the flag is set again on every cycle in which the synchronized input is low, so a clear has no lasting effect while the level persists.
- R5: Source-select bit k = 1 makes channel k use `alt_in[k]` and 0 makes it use `pin_in[k]`, for k from 2 to 15. Bits 0 and 1 always read 0, and channels 0 and 1 always use their pin. The unselected input of any channel has no effect on its flag.
- R6: `irq_req[k]` equals flag k AND enable bit k, with no added delay.
- R7: Writing 0 to flag bit k clears it only if a read of the flag word has returned bit k as 1 since the last write to the flag word. Writing 1 never changes a flag. Once set, a flag stays set until such a clear.
- R8: When a clear and a new detection on the same channel fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Dedicated request inputs, one per channel |
| alt_in | input | 16 | Alternative request inputs; bits 0 and 1 unused |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word, combinational |
| irq_req | output | 16 | Per-channel request to the priority unit |

## Verification
A wrong sense decode or a stale edge sample shows as a flag word that is set, or left clear, three cycles after an input transition. A mix-up in the source multiplexer makes a flag set from the input that is not selected, within the same three cycles. A faulty clear guard shows on the very next read of the flag word: a flag vanishes that software never saw, or survives a clear that should have worked, or drops while a level or a concurrent edge should hold it. Enable gating errors appear at once on `irq_req`. The sweep covers every channel, mode and source choice, so each of these faults surfaces within a few dozen cycles of the scenario that exercises it.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_BOTH = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 16,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // cycles since reset, saturating, so $past never reaches before reset
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2: output is the input delayed by exactly two clocks
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e mode,
  input  logic   clr,
  output logic   flag,
  output logic   det
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= smp;
  end

  always_comb begin
    unique case (mode)
      SNS_LOW:  det = ~smp;
      SNS_FALL: det = prev & ~smp;
      SNS_RISE: det = ~prev & smp;
      SNS_BOTH: det = prev ^ smp;
      default:  det = 1'b0;
    endcase
  end

  // set dominates clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= det | (flag & ~clr);
  end

  // R8: a detection always leaves the flag set next cycle
  a_r8_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> flag);

  // R4: a low level in level mode keeps the flag set
  a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LOW && !smp) |=> flag);

  // R7: without detection or clear, the flag keeps its value
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!det && !clr) |=> $stable(flag));

  // R3: a flag rises only after a matching condition
  a_r3_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(det));
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int NCH       = 16,
  parameter int AW        = 3,
  parameter int ALT_FIRST = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NCH-1:0]     bus_wdata,
  output logic [NCH-1:0]     bus_rdata,
  input  logic [NCH-1:0]     flags,
  output logic [2*NCH-1:0]   sense,
  output logic [NCH-1:0]     src_sel,
  output logic [NCH-1:0]     enable,
  output logic [NCH-1:0]     clr
);
  localparam int SWORDS = 2;
  localparam logic [AW-1:0] A_SRC  = AW'(SWORDS);
  localparam logic [AW-1:0] A_EN   = AW'(SWORDS + 1);
  localparam logic [AW-1:0] A_FLAG = AW'(SWORDS + 2);
  localparam logic [NCH-1:0] SRC_MASK = ~NCH'((1 << ALT_FIRST) - 1);

  logic wr, rd;
  logic [NCH-1:0] seen;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense   <= '0;
      src_sel <= '0;
      enable  <= '0;
    end else if (wr) begin
      for (int w = 0; w < SWORDS; w++) begin
        if (bus_addr == AW'(w)) sense[w*NCH +: NCH] <= bus_wdata;
      end
      if (bus_addr == A_SRC) src_sel <= bus_wdata & SRC_MASK;
      if (bus_addr == A_EN)  enable  <= bus_wdata;
    end
  end

  // bits read as 1 become clearable; any flag-word write consumes them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen <= '0;
    else if (wr && bus_addr == A_FLAG)   seen <= '0;
    else if (rd && bus_addr == A_FLAG)   seen <= seen | flags;
  end

  assign clr = (wr && bus_addr == A_FLAG) ? (~bus_wdata & seen) : '0;

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < SWORDS; w++) begin
      if (bus_addr == AW'(w)) bus_rdata = sense[w*NCH +: NCH];
    end
    if (bus_addr == A_SRC)  bus_rdata = src_sel;
    if (bus_addr == A_EN)   bus_rdata = enable;
    if (bus_addr == A_FLAG) bus_rdata = flags;
  end

  // R5: the low source-select bits never hold a 1
  a_r5_low_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel & ~SRC_MASK) == '0);
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import eirq_pkg::*;
#(
  parameter int NCH       = 16,
  parameter int AW        = 3,
  parameter int ALT_FIRST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pin_in,
  input  logic [NCH-1:0]  alt_in,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NCH-1:0]  bus_wdata,
  output logic [NCH-1:0]  bus_rdata,
  output logic [NCH-1:0]  irq_req
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(4);

  logic [NCH-1:0]   pin_s, alt_s, chosen, flag, det, clr, src_sel, enable;
  logic [2*NCH-1:0] sense;

  eirq_sync #(.W(NCH), .RST_VAL(1'b1)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

  eirq_sync #(.W(NCH), .RST_VAL(1'b1)) u_sync_alt (
    .clk(clk), .rst_n(rst_n), .d(alt_in), .q(alt_s));

  eirq_regs #(.NCH(NCH), .AW(AW), .ALT_FIRST(ALT_FIRST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags(flag), .sense(sense), .src_sel(src_sel),
    .enable(enable), .clr(clr));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i >= ALT_FIRST) begin : g_mux
      assign chosen[i] = src_sel[i] ? alt_s[i] : pin_s[i];
    end else begin : g_pin
      assign chosen[i] = pin_s[i];
    end

    eirq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .smp(chosen[i]),
      .mode(sense_e'(sense[2*i +: 2])), .clr(clr[i]),
      .flag(flag[i]), .det(det[i]));

    assign irq_req[i] = flag[i] & enable[i];

    // R7: a flag drops only after a 0 was written to its bit
    a_r7_fall_only_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |->
        $past(bus_en && bus_we && bus_addr == FLAG_ADDR && !bus_wdata[i]));
  end
endmodule

// File: tb/ext_irq_latch_bench.sv
module ext_irq_latch_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] pin, alt, wdata, rdata, req;
  logic         ben, bwe;
  logic [2:0]   addr;
  logic [N-1:0] last_req;
  int checks = 0, fails = 0;

  ext_irq_latch u_ext_irq_latch (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .alt_in(alt),
    .bus_en(ben), .bus_we(bwe), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_req(req));

  task automatic chk(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); ben = 1; bwe = 1; addr = a; wdata = d;
    @(negedge clk); ben = 0; bwe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); ben = 1; bwe = 0; addr = a;
    #1 d = rdata; last_req = req;
    @(negedge clk); ben = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [N-1:0] t;
    rd(3'd4, t);
    wr(3'd4, '0);
  endtask

  task automatic chk_flags(input string rq, input logic [N-1:0] exp, input logic [N-1:0] en_w);
    logic [N-1:0] f;
    rd(3'd4, f);
    chk(rq, f, exp);
    chk("R6 request gating", last_req, exp & en_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    pin = '1; alt = '1; ben = 0; bwe = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of every address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset register value", v, '0);
      chk("R1 reset request", last_req, '0);
    end

    // R5: low source-select bits stay 0
    wr(3'd2, '1); rd(3'd2, v); chk("R5 source select readback", v, 16'hFFFC);

    // Sweep: every channel, mode, source choice
    for (int ch = 0; ch < N; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int ua = 0; ua < 2; ua++) begin
          logic [1:0]   m2;
          logic [N-1:0] bit_w, en_w;
          logic         sel_alt;
          m2 = 2'(m);
          bit_w = N'(1) << ch;
          en_w = (((ch + m + ua) % 2) == 0) ? '1 : '0;
          sel_alt = (ua == 1) && (ch >= 2);
          wr(3'd0, {8{m2}}); wr(3'd1, {8{m2}});
          wr(3'd2, ua == 1 ? '1 : '0);
          wr(3'd3, en_w);
          pin = '1; alt = '1;
          settle(); clear_all(); settle();

          // unselected input toggles: no effect (R5)
          if (sel_alt) pin[ch] = 1'b0; else alt[ch] = 1'b0;
          settle(); chk_flags("R5 unselected low", '0, en_w);
          if (sel_alt) pin[ch] = 1'b1; else alt[ch] = 1'b1;
          settle(); chk_flags("R5 unselected high", '0, en_w);

          // selected input falls (R3, R2)
          if (sel_alt) alt[ch] = 1'b0; else pin[ch] = 1'b0;
          settle();
          chk_flags("R3 after fall", (m2 != 2'b10) ? bit_w : '0, en_w);

          // clear while low (R4)
          clear_all(); settle();
          chk_flags("R4 clear during low", (m2 == 2'b00) ? bit_w : '0, en_w);

          // selected input rises (R3)
          if (sel_alt) alt[ch] = 1'b1; else pin[ch] = 1'b1;
          settle();
          chk_flags("R3 after rise", (m2 == 2'b00 || m2[1]) ? bit_w : '0, en_w);

          // clear after read works (R7)
          clear_all(); settle();
          chk_flags("R7 clear after read", '0, en_w);
        end
      end
    end

    // R2: flag not yet set two edges after the change, set after the third
    wr(3'd0, {8{2'b01}}); wr(3'd1, {8{2'b01}}); wr(3'd2, '0); wr(3'd3, '1);
    pin = '1; alt = '1; settle(); clear_all(); settle();
    @(negedge clk); pin[6] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet visible", req, '0);
    @(negedge clk);
    chk("R2 visible on third edge", req, 16'h0040);

    // R7: write of 0 without a fresh read does not clear; write 1 no effect
    wr(3'd4, '1);
    wr(3'd4, '0);
    rd(3'd4, v); chk("R7 unread clear ignored", v, 16'h0040);
    wr(3'd4, '1);
    rd(3'd4, v); chk("R7 write one ignored", v, 16'h0040);
    wr(3'd4, '0);
    rd(3'd4, v); chk("R7 read then clear", v, '0);
    pin = '1; settle(); clear_all();

    // R8: clear coincides with detection
    wr(3'd0, {8{2'b11}});
    settle(); clear_all(); settle();
    pin[3] = 1'b0; settle();
    rd(3'd4, v); chk("R8 setup flag", v, 16'h0008);
    @(negedge clk); pin[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); ben = 1; bwe = 1; addr = 3'd4; wdata = '0;
    @(negedge clk); ben = 0; bwe = 0;
    rd(3'd4, v); chk("R8 detection wins over clear", v, 16'h0008);
    wr(3'd4, '0);
    rd(3'd4, v); chk("R8 later clear works", v, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule